// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes up to six asynchronous interrupt pins from outside the chip and turns them into clean, clocked request lines for an interrupt controller. Each pin first passes through a synchroniser. A trigger cell for each pin then detects the condition that software selected for it: a rising edge, a falling edge, either edge, a high level or a low level.

The cell records the condition in a pending bit. An enable bit gates that pending bit onto the pin's request output. Software works through a small 32-bit register window. One word holds a four-bit trigger field for every pin. A read-only word shows the synchronised pin levels. The remaining two words hold the pending bits and the enable bits.

Edge triggers latch until software clears them. Level triggers track the pin. This lets a driver use either style of source without extra glue logic.

Top module: `xirq_cond`

## Requirements
- R1: The trigger word at address 0x0 holds one four-bit field per pin, pin i at bits [4i+3:4i] (pin 5 at bits [23:20]). Reads return the written value for bits [23:0], and bits [31:24] read as zero.
- R2: Each pin goes through a two-flop synchroniser. Address 0x4 reads the synchronised levels in bits [5:0], and those levels change on the second rising clock edge after the pin changes. Writes to 0x4 have no effect.
- R3: Trigger code 1 (rising edge) sets the pin's pending bit. With the pin enabled, its output rises after the third rising clock edge that follows the pin change, and not before.
- R4: Trigger code 2 (falling edge) sets pending on a high-to-low change only. A steady high level or a rise does not set it.
- R5: Trigger code 3 sets pending on both a rise and a fall.
- R6: Trigger code 5 (high level) makes pending follow the synchronised level, with the same latency as an edge. A software clear does not drop it while the pin stays high.
- R7: Trigger code 6 (low level) makes pending follow the inverse of the synchronised level.
- R8: Code 0 and the unused codes 4 and 7 to 15 never set pending, whatever the pin does.
- R9: An edge-set pending bit stays set until software writes address 0x8 with that bit at 0. Writing a 1 to a bit leaves it unchanged.
- R10: The enable word at 0x0C has one bit per pin in bits [5:0], and the upper bits read as zero. A pin whose enable bit is 0 never drives its output high, but its pending bit is still recorded and readable at 0x8.
- R11: After reset every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Write strobe for one clock cycle |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 6 | Per-pin request lines, pending AND enable |

## Verification
The assertions take for granted that the bus signals are known whenever the write strobe is high. They also take for granted that a pin's trigger field is judged on the value it has in the cycle before each clock edge. The bench meets both: it changes the bus and the pins only on falling clock edges, and it holds every pin level for at least three cycles so that each edge reaches both synchroniser stages and the edge-detect register. Level checks compare pending with the synchronised sample rather than with the raw pin, so pin changes that are truly asynchronous would not break them.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   localparam int unsigned TRIG_W = 4;

   typedef enum logic [TRIG_W-1:0] {
      TRIG_OFF  = 4'd0,
      TRIG_RISE = 4'd1,
      TRIG_FALL = 4'd2,
      TRIG_BOTH = 4'd3,
      TRIG_HIGH = 4'd5,
      TRIG_LOW  = 4'd6
   } trig_e;

   typedef struct packed {
      logic on_rise;
      logic on_fall;
      logic lvl_high;
      logic lvl_low;
   } trig_sel_t;

   localparam logic [3:0] OFF_TRIG  = 4'h0;
   localparam logic [3:0] OFF_LEVEL = 4'h4;
   localparam logic [3:0] OFF_PEND  = 4'h8;
   localparam logic [3:0] OFF_ENA   = 4'hC;

   function automatic trig_sel_t trig_decode(input logic [TRIG_W-1:0] code);
      trig_sel_t s;
      s = '0;
      case (code)
         TRIG_RISE: s.on_rise = 1'b1;
         TRIG_FALL: s.on_fall = 1'b1;
         TRIG_BOTH: begin
            s.on_rise = 1'b1;
            s.on_fall = 1'b1;
         end
         TRIG_HIGH: s.lvl_high = 1'b1;
         TRIG_LOW:  s.lvl_low  = 1'b1;
         default:   s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[k] <= '0;
         else        stage_q[k] <= stage_q[k-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/xirq_cell.sv
module xirq_cell
   import xirq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIG_W-1:0] trig,
   input  logic              smp,
   input  logic              sw_clr,
   output logic              pend
);

   logic      prev_q;
   logic      pend_q;
   trig_sel_t sel;
   logic      hit;
   logic      is_level;
   logic      level_val;

   assign sel       = trig_decode(trig);
   assign hit       = (sel.on_rise & smp & ~prev_q) | (sel.on_fall & ~smp & prev_q);
   assign is_level  = sel.lvl_high | sel.lvl_low;
   assign level_val = sel.lvl_high ? smp : ~smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= smp;
         if (is_level)    pend_q <= level_val;
         else if (hit)    pend_q <= 1'b1;
         else if (sw_clr) pend_q <= 1'b0;
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   input  logic [NUM_PINS-1:0]        pin_lvl,
   input  logic [NUM_PINS-1:0]        pend,
   output logic [NUM_PINS*TRIG_W-1:0] trig_q,
   output logic [NUM_PINS-1:0]        ena_q,
   output logic [NUM_PINS-1:0]        clr,
   output logic [DATA_W-1:0]          bus_rdata
);

   localparam int unsigned TRIG_BITS = NUM_PINS * TRIG_W;

   logic hit_trig, hit_level, hit_pend, hit_ena;
   logic unused_wdata;

   assign hit_trig  = (bus_addr == ADDR_W'(OFF_TRIG));
   assign hit_level = (bus_addr == ADDR_W'(OFF_LEVEL));
   assign hit_pend  = (bus_addr == ADDR_W'(OFF_PEND));
   assign hit_ena   = (bus_addr == ADDR_W'(OFF_ENA));

   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
         ena_q  <= '0;
      end else if (bus_wr) begin
         if (hit_trig) trig_q <= bus_wdata[TRIG_BITS-1:0];
         if (hit_ena)  ena_q  <= bus_wdata[NUM_PINS-1:0];
      end
   end

   assign clr = (bus_wr && hit_pend) ? ~bus_wdata[NUM_PINS-1:0] : '0;

   always_comb begin
      bus_rdata = '0;
      if (hit_trig)  bus_rdata = DATA_W'(trig_q);
      if (hit_level) bus_rdata = DATA_W'(pin_lvl);
      if (hit_pend)  bus_rdata = DATA_W'(pend);
      if (hit_ena)   bus_rdata = DATA_W'(ena_q);
   end

endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] irq_out
);

   localparam int unsigned TRIG_BITS = NUM_PINS * TRIG_W;

   if (NUM_PINS < 1 || TRIG_BITS > DATA_W) begin : g_bad_pins
      $error("xirq_cond: NUM_PINS trigger fields must fit in DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xirq_cond: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("xirq_cond: ADDR_W must reach offset 0xC");
   end

   logic [NUM_PINS-1:0]  pin_sync;
   logic [NUM_PINS-1:0]  pend_q;
   logic [NUM_PINS-1:0]  ena_q;
   logic [NUM_PINS-1:0]  clr;
   logic [TRIG_BITS-1:0] trig_q;

   xirq_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_sync)
   );

   xirq_regs #(
      .NUM_PINS(NUM_PINS),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .pin_lvl  (pin_sync),
      .pend     (pend_q),
      .trig_q   (trig_q),
      .ena_q    (ena_q),
      .clr      (clr),
      .bus_rdata(bus_rdata)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      xirq_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (trig_q[p*TRIG_W +: TRIG_W]),
         .smp   (pin_sync[p]),
         .sw_clr(clr[p]),
         .pend  (pend_q[p])
      );
   end

   assign irq_out = pend_q & ena_q;

endmodule

// File: rtl/xirq_cond_chk.sv
module xirq_cond_chk
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic [NUM_PINS*TRIG_W-1:0] trig_q,
   input logic [NUM_PINS-1:0]        smp,
   input logic [NUM_PINS-1:0]        pend_q,
   input logic [NUM_PINS-1:0]        irq_out
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
      logic [TRIG_W-1:0] code;
      logic edge_mode, none_mode, clr_wr, ena_off_wr;

      assign code       = trig_q[p*TRIG_W +: TRIG_W];
      assign edge_mode  = (code == 4'd1) || (code == 4'd2) || (code == 4'd3);
      assign none_mode  = !edge_mode && (code != 4'd5) && (code != 4'd6);
      assign clr_wr     = bus_wr && (bus_addr == ADDR_W'(OFF_PEND)) && !bus_wdata[p];
      assign ena_off_wr = bus_wr && (bus_addr == ADDR_W'(OFF_ENA)) && !bus_wdata[p];

      assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[p] && edge_mode && !clr_wr) |=> pend_q[p]);

      assert_high_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (code == 4'd5) |=> (pend_q[p] == $past(smp[p])));

      assert_low_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (code == 4'd6) |=> (pend_q[p] == !$past(smp[p])));

      assert_no_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (none_mode && !pend_q[p]) |=> !pend_q[p]);

      assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ena_off_wr |=> !irq_out[p]);
   end

endmodule

bind xirq_cond xirq_cond_chk #(
   .NUM_PINS(NUM_PINS),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .trig_q   (trig_q),
   .smp      (pin_sync),
   .pend_q   (pend_q),
   .irq_out  (irq_out)
);

// File: tb/xirq_cond_bench.sv
module xirq_cond_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  pin_in = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xirq_cond u_xirq_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_out  (irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pins(input logic [5:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R11 irq after reset", 32'(irq_out), 32'h0);
      rd(4'h0, d); check("R11 trig word", d, 32'h0);
      rd(4'h4, d); check("R11 level word", d, 32'h0);
      rd(4'h8, d); check("R11 pending word", d, 32'h0);
      rd(4'hC, d); check("R11 enable word", d, 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R1 upper bits zero", d, 32'h00FF_FFFF);
      wr(4'h0, 32'hAB65_4321);
      rd(4'h0, d); check("R1 field readback", d, 32'h0065_4321);
      wr(4'h0, 32'h0);
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, d); check("R10 enable width", d, 32'h0000_003F);
   endtask

   task automatic t_sync();
      @(negedge clk);
      pin_in = 6'b101101; bus_addr = 4'h4;
      @(posedge clk); #2;
      check("R2 level after one edge", bus_rdata, 32'h0);
      @(posedge clk); #2;
      check("R2 level after two edges", bus_rdata, 32'h2D);
      wr(4'h4, 32'h0);
      @(negedge clk); bus_addr = 4'h4; #1;
      check("R2 write to level ignored", bus_rdata, 32'h2D);
      pins(6'b0); settle();
      wr(4'h8, 32'h0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(4'h0, 32'h0010_0001);
      wr(4'h8, 32'h0);
      pins(6'b100001);
      repeat (2) @(posedge clk); #2;
      check("R3 no output before third edge", 32'(irq_out), 32'h0);
      @(posedge clk); #2;
      check("R3 rise on pins 0 and 5", 32'(irq_out), 32'h21);
      pins(6'b0); settle();
      check("R9 pending held after fall", 32'(irq_out), 32'h21);
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, d); check("R9 writing ones keeps pending", d, 32'h21);
      wr(4'h8, 32'h0000_003E);
      rd(4'h8, d); check("R9 clear only bit 0", d, 32'h20);
      wr(4'h8, 32'h0);
      rd(4'h8, d); check("R9 clear all", d, 32'h0);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(4'h0, 32'h0);
      pins(6'b000100); settle();
      wr(4'h0, 32'h0000_0200);
      wr(4'h8, 32'h0); settle();
      rd(4'h8, d); check("R4 steady high no trigger", d, 32'h0);
      pins(6'b0); settle();
      check("R4 fall on pin 2", 32'(irq_out), 32'h04);
      wr(4'h8, 32'h0);
      pins(6'b000100); settle();
      check("R4 rise ignored", 32'(irq_out), 32'h0);
      pins(6'b0); settle();
      wr(4'h8, 32'h0);
   endtask

   task automatic t_both();
      wr(4'h0, 32'h0000_3000);
      wr(4'h8, 32'h0);
      pins(6'b001000); settle();
      check("R5 rise on pin 3", 32'(irq_out), 32'h08);
      wr(4'h8, 32'h0);
      check("R5 cleared", 32'(irq_out), 32'h0);
      pins(6'b0); settle();
      check("R5 fall on pin 3", 32'(irq_out), 32'h08);
      wr(4'h8, 32'h0);
   endtask

   task automatic t_high();
      wr(4'h0, 32'h0000_0050);
      settle();
      check("R6 low pin not pending", 32'(irq_out), 32'h0);
      pins(6'b000010);
      repeat (2) @(posedge clk); #2;
      check("R6 latency", 32'(irq_out), 32'h0);
      @(posedge clk); #2;
      check("R6 high level", 32'(irq_out), 32'h02);
      wr(4'h8, 32'h0); #2;
      check("R6 clear ignored while high", 32'(irq_out), 32'h02);
      pins(6'b0); settle();
      check("R6 follows drop", 32'(irq_out), 32'h0);
   endtask

   task automatic t_low();
      wr(4'h0, 32'h0006_0000);
      settle();
      check("R7 low level pending", 32'(irq_out), 32'h10);
      pins(6'b010000); settle();
      check("R7 high releases", 32'(irq_out), 32'h0);
      pins(6'b0); settle();
      check("R7 low again", 32'(irq_out), 32'h10);
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h0);
   endtask

   task automatic t_none();
      logic [31:0] d;
      wr(4'h0, 32'h008A_F740);
      wr(4'h8, 32'h0);
      pins(6'b111111); settle();
      rd(4'h8, d); check("R8 unused codes on rise", d, 32'h0);
      pins(6'b0); settle();
      rd(4'h8, d); check("R8 unused codes on fall", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(4'hC, 32'h0);
      wr(4'h0, 32'h0000_0001);
      wr(4'h8, 32'h0);
      pins(6'b000001); settle();
      check("R10 disabled output low", 32'(irq_out), 32'h0);
      rd(4'h8, d); check("R10 pending still recorded", d, 32'h01);
      wr(4'hC, 32'h0000_0001);
      check("R10 enable passes pending", 32'(irq_out), 32'h01);
      wr(4'hC, 32'h0);
      check("R10 disable drops output", 32'(irq_out), 32'h0);
      pins(6'b0); settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_fields();
      t_sync();
      t_rise();
      t_fall();
      t_both();
      t_high();
      t_low();
      t_none();
      t_enable();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule